// File: doc/BRIEF.md
# Address-Latched One-Hot Select Decoder

This block turns a binary select code into a one-hot strobe vector. The code does not reach the decoder directly. It first passes through a level-sensitive holding latch. While the hold control is low, the latch passes the code straight through, so the outputs track the live code. When the hold control rises, the latch keeps the code that was present just before the rise. It ignores the code inputs until the hold control falls again. This lets a bus master place an address, freeze it, and then move on while the strobe stays put.

Two gating inputs of opposite polarity decide whether any strobe is driven. One is active-low and the other active-high. They act after the latch, so switching them never disturbs the stored code. Because of this, one cell can drive the gates of others. With the default parameters, the top level is a two-tier tree of nine identical cells. A front cell decodes the upper code bits and enables one of eight back cells, which decode the lower bits. All nine cells share one hold control, so the full 6-bit code is frozen as a unit. Setting the tier count to one gives a single cell. An asynchronous active-low clear empties every latch to code 0.

Top module: `latched_dec_tree`

## Requirements
- R1: While `hold` is low and the design is out of clear, the outputs follow the live `sel_i` with no added cycles.
- R2: On a rise of `hold`, the code on `sel_i` just before the rise is kept. Changes on `sel_i` while `hold` stays high leave the outputs unchanged.
- R3: At no time is more than one bit of `strobe_o` high.
- R4: Strobes are driven only when `gate_n` is 0 and `gate` is 1. With any other gate combination, all of `strobe_o` is 0.
- R5: Toggling `gate_n` or `gate` while `hold` is high neither changes nor reloads the kept code. After the gates reopen, the strobe of the previously kept code returns.
- R6: Bit 0 of `sel_i` is the least significant. Code value k drives `strobe_o[k]`: code 1 drives bit 1, code 4 drives bit 4, and code 8 (first code of the second back cell) drives bit 8.
- R7: In the two-tier tree, exactly one of the 64 strobes is high whenever the gates are open.
- R8: While `clr_n` is low, every kept code is 0 whatever `hold` does. With the gates open, only `strobe_o[0]` is high. After release with `hold` high, code 0 is still kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clr_n | input | 1 | Asynchronous active-low clear of all kept codes |
| hold | input | 1 | Low: latches pass the code; rising: freeze the code |
| gate_n | input | 1 | Active-low output gate |
| gate | input | 1 | Active-high output gate |
| sel_i | input | SEL_W*LEVELS (6) | Binary select code, bit 0 least significant |
| strobe_o | output | 2**(SEL_W*LEVELS) (64) | One-hot active-high strobes |

## Verification
Every result of this block is due in the same cycle as its stimulus. The path from `sel_i`, `hold`, the gates and `clr_n` to `strobe_o` contains only latches and gates, with no flip-flops. So the bench changes inputs just after a rising clock edge and samples at the following falling edge, half a period later. By then the latches and the decode have settled. The reference model updates its kept code only when `hold` is low or clear is active. The stimulus never changes `sel_i` in the same step that `hold` rises, so the captured value is never ambiguous.

// File: rtl/dec_pkg.sv
package dec_pkg;

    // Default code width of one decoder cell
    localparam int unsigned CELL_SEL_W = 3;

    // Gating rule shared by every cell: open only for active-low 0 and active-high 1
    function automatic logic gate_open(input logic g_n, input logic g);
        return (!g_n) && g;
    endfunction

endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
    parameter int unsigned W = dec_pkg::CELL_SEL_W
) (
    input  logic         clr_n,
    input  logic         hold,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] code;
    } hold_t;

    hold_t hold_d;
    hold_t hold_q;

    always_comb begin
        hold_d      = hold_q;
        hold_d.code = d_i;
    end

    // Transparent while hold is low; clear has priority
    always_latch begin
        if (!clr_n) begin
            hold_q <= '0;
        end else if (!hold) begin
            hold_q <= hold_d;
        end
    end

    assign q_o = hold_q.code;

endmodule

// File: rtl/sel_decode.sv
module sel_decode #(
    parameter int unsigned W = dec_pkg::CELL_SEL_W,
    localparam int unsigned N = 1 << W
) (
    input  logic         gate_n,
    input  logic         gate,
    input  logic [W-1:0] code_i,
    output logic [N-1:0] hot_o
);

    always_comb begin
        hot_o = '0;
        if (dec_pkg::gate_open(gate_n, gate)) begin
            hot_o[code_i] = 1'b1;
        end
    end

endmodule

// File: rtl/dec_cell.sv
module dec_cell #(
    parameter int unsigned W = dec_pkg::CELL_SEL_W,
    localparam int unsigned N = 1 << W
) (
    input  logic         clr_n,
    input  logic         hold,
    input  logic         gate_n,
    input  logic         gate,
    input  logic [W-1:0] code_i,
    output logic [N-1:0] hot_o
);

    logic [W-1:0] kept_code;

    addr_hold #(.W(W)) u_hold (
        .clr_n (clr_n),
        .hold  (hold),
        .d_i   (code_i),
        .q_o   (kept_code)
    );

    sel_decode #(.W(W)) u_dec (
        .gate_n (gate_n),
        .gate   (gate),
        .code_i (kept_code),
        .hot_o  (hot_o)
    );

endmodule

// File: rtl/latched_dec_tree.sv
module latched_dec_tree #(
    parameter int unsigned SEL_W  = dec_pkg::CELL_SEL_W,
    parameter int unsigned LEVELS = 2,
    localparam int unsigned CODE_W = SEL_W * LEVELS,
    localparam int unsigned OUT_W  = 1 << CODE_W
) (
    input  logic              clr_n,
    input  logic              hold,
    input  logic              gate_n,
    input  logic              gate,
    input  logic [CODE_W-1:0] sel_i,
    output logic [OUT_W-1:0]  strobe_o
);

    localparam int unsigned CELL_N = 1 << SEL_W;

    generate
        if (LEVELS == 1) begin : g_single
            dec_cell #(.W(SEL_W)) u_cell (
                .clr_n  (clr_n),
                .hold   (hold),
                .gate_n (gate_n),
                .gate   (gate),
                .code_i (sel_i),
                .hot_o  (strobe_o)
            );
        end else begin : g_tree
            logic [CELL_N-1:0] grp_en;

            // Front cell: upper code bits pick one back cell
            dec_cell #(.W(SEL_W)) u_front (
                .clr_n  (clr_n),
                .hold   (hold),
                .gate_n (gate_n),
                .gate   (gate),
                .code_i (sel_i[CODE_W-1 -: SEL_W]),
                .hot_o  (grp_en)
            );

            // Back cells: lower code bits, gated by the front strobe
            for (genvar g = 0; g < CELL_N; g++) begin : g_back
                dec_cell #(.W(SEL_W)) u_back (
                    .clr_n  (clr_n),
                    .hold   (hold),
                    .gate_n (1'b0),
                    .gate   (grp_en[g]),
                    .code_i (sel_i[SEL_W-1:0]),
                    .hot_o  (strobe_o[g*CELL_N +: CELL_N])
                );
            end
        end
    endgenerate

    logic gates_on;
    assign gates_on = (gate_n == 1'b0) && (gate == 1'b1);

    always_comb begin
        // R3
        onehot_out_chk: assert ($onehot0(strobe_o));
        // R4
        if (!gates_on) begin
            gate_off_chk: assert (strobe_o == '0);
        end
        // R7
        if (clr_n && gates_on) begin
            one_live_chk: assert ($countones(strobe_o) == 1);
        end
        // R1
        if (clr_n && !hold && gates_on) begin
            follow_chk: assert (strobe_o[sel_i] == 1'b1);
        end
        // R8
        if (!clr_n && gates_on) begin
            clear_code_chk: assert (strobe_o[0] == 1'b1);
        end
    end

endmodule

// File: tb/tb_latched_dec_tree.sv
module tb_latched_dec_tree;

    localparam int unsigned CODE_W = 6;
    localparam int unsigned OUT_W  = 64;
    localparam int unsigned WD_LIMIT = 50000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              clr_n  = 1'b0;
    logic              hold   = 1'b1;
    logic              gate_n = 1'b0;
    logic              gate   = 1'b1;
    logic [CODE_W-1:0] sel    = '0;
    logic [OUT_W-1:0]  strobe;

    latched_dec_tree dut (
        .clr_n    (clr_n),
        .hold     (hold),
        .gate_n   (gate_n),
        .gate     (gate),
        .sel_i    (sel),
        .strobe_o (strobe)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    logic [CODE_W-1:0] kept = '0;

    function automatic logic [OUT_W-1:0] expect_strobe(input logic [CODE_W-1:0] k,
                                                       input logic gn, input logic gp);
        if (!gn && gp) return {{(OUT_W-1){1'b0}}, 1'b1} << k;
        return '0;
    endfunction

    task automatic step(input logic r, input logic h, input logic gn, input logic gp,
                        input logic [CODE_W-1:0] a, input string tag);
        logic [OUT_W-1:0] exp_v;
        @(posedge clk);
        clr_n  = r;
        hold   = h;
        gate_n = gn;
        gate   = gp;
        sel    = a;
        if (!r)      kept = '0;
        else if (!h) kept = a;
        exp_v = expect_strobe(kept, gn, gp);
        @(negedge clk);
        total++;
        if (strobe !== exp_v) begin
            bad++;
            $display("FAIL %s strobe=%h expected=%h", tag, strobe, exp_v);
        end
        total++;
        if ($countones(strobe) > 1) begin
            bad++;
            $display("FAIL R3 ones=%0d expected<=1", $countones(strobe));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog cycles=%0d expected<%0d", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);

        // R8: clear holds code 0 while hold is high
        step(1'b0, 1'b1, 1'b0, 1'b1, 6'd9, "R8");
        step(1'b1, 1'b1, 1'b0, 1'b1, 6'd9, "R8");

        // R1 / R4: transparent sweep over every code and gate pair
        for (int a = 0; a < 64; a++) begin
            for (int e = 0; e < 4; e++) begin
                step(1'b1, 1'b0, e[1], e[0], a[CODE_W-1:0], (e == 1) ? "R1" : "R4");
            end
        end

        // R6: bit ordering and group boundary
        step(1'b1, 1'b0, 1'b0, 1'b1, 6'd1, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b1, 6'd4, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b1, 6'd8, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b1, 6'd63, "R6");

        // R2: capture then ignore code changes
        step(1'b1, 1'b0, 1'b0, 1'b1, 6'd37, "R2");
        step(1'b1, 1'b1, 1'b0, 1'b1, 6'd37, "R2");
        for (int k = 0; k < 64; k += 7) begin
            step(1'b1, 1'b1, 1'b0, 1'b1, k[CODE_W-1:0], "R2");
        end

        // R5: gate toggles during hold keep the code
        step(1'b1, 1'b1, 1'b1, 1'b1, 6'd5,  "R5");
        step(1'b1, 1'b1, 1'b0, 1'b0, 6'd12, "R5");
        step(1'b1, 1'b1, 1'b1, 1'b0, 6'd50, "R5");
        step(1'b1, 1'b1, 1'b0, 1'b1, 6'd20, "R5");

        // R1: release hold, follow again
        step(1'b1, 1'b0, 1'b0, 1'b1, 6'd20, "R1");

        // R8: clear during hold, then release clear with hold still high
        step(1'b1, 1'b1, 1'b0, 1'b1, 6'd20, "R8");
        step(1'b0, 1'b1, 1'b0, 1'b1, 6'd3,  "R8");
        step(1'b1, 1'b1, 1'b0, 1'b1, 6'd3,  "R8");

        // R7: constrained random mix, no code change on a hold rise
        begin
            logic prev_h;
            logic [CODE_W-1:0] prev_a;
            prev_h = 1'b1;
            prev_a = 6'd3;
            for (int i = 0; i < 2000; i++) begin
                logic h, gn, gp;
                logic [CODE_W-1:0] a;
                h  = ($urandom % 3) == 0;
                gn = ($urandom % 5) == 0;
                gp = ($urandom % 5) != 0;
                a  = CODE_W'($urandom);
                if (h && !prev_h) a = prev_a;
                step(1'b1, h, gn, gp, a, "R7");
                prev_h = h;
                prev_a = a;
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule